// File: doc/BRIEF.md
# Transmit Word Queue with Send Gating

This block buffers 32-bit words on their way from a command front end to a serial line transmitter. It stores up to 32 words in arrival order, reports whether it is empty, at least half full or completely full, and presents the oldest word to the serializer in first-word-fall-through form. A synchronous clear discards everything it holds in one cycle.

The queue also owns the decision of when words may leave. In automatic mode any held word is offered to the serializer at once. In manual mode words are held until a send trigger arrives; from then on the queue keeps offering words, including words pushed while it drains, until it is empty and the serializer reports that its last word has finished. Words pushed after that point wait for the next trigger.

The half-full flag is meant for software that writes in blocks of 16 words: while it reads 0, a full block fits. Pushes into a full queue are dropped without notice unless a word leaves in the same cycle.

Top module: `txq_word_queue`

## Requirements
- R1: During and directly after reset the queue holds no words: `level` is 0, `empty` is 1, `half_full`, `full`, `sending` and `pop_valid` are 0.
- R2: Words leave in the order they were accepted; whenever `pop_valid` is 1, `pop_data` is the oldest held word.
- R3: `empty` is 1 exactly when `level` is 0.
- R4: `half_full` is 0 while fewer than 16 words are held and 1 when 16 or more are held.
- R5: `full` is 1 when 32 words are held; a push into a full queue with no pop in the same cycle is ignored and leaves the level and the stored words unchanged.
- R6: A push and a pop in the same cycle on a full queue are both accepted; the level stays at 32 and the pushed word joins the tail.
- R7: `clear` empties the queue at the next clock edge and wins over a push in the same cycle, whose word is discarded; `pop_valid` is 0 during a clear cycle.
- R8: With `auto_send` at 1, `pop_valid` is 1 in every cycle in which the queue holds a word and `clear` is 0.
- R9: With `auto_send` at 0, held words are not offered (`pop_valid` 0) until `send_trigger` is sampled at a clock edge; from the following cycle `sending` is 1 and words are offered.
- R10: `sending` stays 1 while words remain or while `ser_busy` is 1, so words pushed before the queue drains are also sent; it returns to 0 at the edge where the queue is empty, `ser_busy` is 0 and no trigger is present, after which new words are held.
- R11: A pop happens at the clock edge where `pop_valid` and `pop_ready` are both 1 and lowers the level by one unless a push is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push request from the command front end |
| push_data | input | 32 | Word to store |
| clear | input | 1 | Synchronous discard of all held words |
| auto_send | input | 1 | 1: offer words as soon as held; 0: wait for a trigger |
| send_trigger | input | 1 | Start sending in manual mode |
| ser_busy | input | 1 | Serializer is still shifting out a word |
| pop_ready | input | 1 | Serializer takes the offered word |
| pop_valid | output | 1 | A word is offered to the serializer |
| pop_data | output | 32 | Oldest held word |
| level | output | 6 | Number of words held |
| empty | output | 1 | No words held |
| half_full | output | 1 | 16 or more words held |
| full | output | 1 | 32 words held |
| sending | output | 1 | Manual send cycle in progress |

## Verification
A wrong level count shows at the flags in the same cycle, since they decode it directly, and the drop-or-accept decision for pushes on a full queue makes any miscount grow into a missing or duplicated word at `pop_data`. A wrong pointer shows at `pop_data` the next time a word leaves, so every popped word is compared against a model of the expected order. A wrong send state shows at once as `pop_valid` asserted while words should be held, or withheld while a drain is in progress, and is visible on `sending` one cycle after the trigger or drain edge.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned TXQ_DEPTH = 32;
    localparam int unsigned TXQ_WIDTH = 32;
    localparam int unsigned TXQ_HALF  = 16;

    // Operation applied to the queue in one cycle, already qualified.
    typedef struct packed {
        logic clr;
        logic push;
        logic pop;
    } txq_op_t;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
    } txq_flags_t;

    typedef enum logic {
        SEND_IDLE   = 1'b0,
        SEND_ACTIVE = 1'b1
    } send_state_t;

    function automatic int unsigned ptr_advance(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

    function automatic txq_flags_t flags_of(int unsigned lvl, int unsigned depth,
                                            int unsigned half);
        txq_flags_t f;
        f.empty = (lvl == 0);
        f.half  = (lvl >= half);
        f.full  = (lvl >= depth);
        return f;
    endfunction

endpackage

// File: rtl/txq_storage.sv
module txq_storage #(
    parameter int unsigned DEPTH = txq_pkg::TXQ_DEPTH,
    parameter int unsigned WIDTH = txq_pkg::TXQ_WIDTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // First-word-fall-through read of the head entry.
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/txq_level_ctrl.sv
module txq_level_ctrl
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = txq_pkg::TXQ_DEPTH,
    parameter int unsigned HALF  = txq_pkg::TXQ_HALF,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  txq_op_t          op,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output txq_flags_t       flags
);

    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst || op.clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (op.push) begin
                wr_ptr_q <= PTR_W'(ptr_advance(32'(wr_ptr_q), DEPTH));
            end
            if (op.pop) begin
                rd_ptr_q <= PTR_W'(ptr_advance(32'(rd_ptr_q), DEPTH));
            end
            unique case ({op.push, op.pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;
    assign level  = level_q;
    assign flags  = flags_of(32'(level_q), DEPTH, HALF);

endmodule

// File: rtl/txq_send_gate.sv
module txq_send_gate
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_send,
    input  logic send_trigger,
    input  logic q_empty,
    input  logic ser_busy,
    output logic send_en,
    output logic sending
);

    send_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEND_IDLE;
        end else begin
            unique case (state_q)
                SEND_IDLE: begin
                    if (send_trigger) begin
                        state_q <= SEND_ACTIVE;
                    end
                end
                SEND_ACTIVE: begin
                    // Leave only once drained and the last word has left the line.
                    if (!send_trigger && q_empty && !ser_busy) begin
                        state_q <= SEND_IDLE;
                    end
                end
                default: state_q <= SEND_IDLE;
            endcase
        end
    end

    assign sending = (state_q == SEND_ACTIVE);
    assign send_en = auto_send || sending;

endmodule

// File: rtl/txq_word_queue.sv
module txq_word_queue
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = txq_pkg::TXQ_DEPTH,
    parameter int unsigned WIDTH = txq_pkg::TXQ_WIDTH,
    parameter int unsigned HALF  = txq_pkg::TXQ_HALF,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             clear,
    input  logic             auto_send,
    input  logic             send_trigger,
    input  logic             ser_busy,
    input  logic             pop_ready,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             half_full,
    output logic             full,
    output logic             sending
);

    txq_op_t          op;
    txq_flags_t       flags;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             send_en;
    logic             pop_fire;

    // Offer the head word only when gated open, something is held and no clear.
    assign pop_valid = send_en && !flags.empty && !clear;
    assign pop_fire  = pop_valid && pop_ready;

    always_comb begin
        op.clr  = clear;
        op.pop  = pop_fire;
        op.push = push_valid && !clear && (!flags.full || pop_fire);
    end

    txq_storage #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_storage (
        .clk     (clk),
        .wr_en   (op.push),
        .wr_addr (wr_ptr),
        .wr_data (push_data),
        .rd_addr (rd_ptr),
        .rd_data (pop_data)
    );

    txq_level_ctrl #(
        .DEPTH (DEPTH),
        .HALF  (HALF)
    ) u_level (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .level  (level),
        .flags  (flags)
    );

    txq_send_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .auto_send    (auto_send),
        .send_trigger (send_trigger),
        .q_empty      (flags.empty),
        .ser_busy     (ser_busy),
        .send_en      (send_en),
        .sending      (sending)
    );

    assign empty     = flags.empty;
    assign half_full = flags.half;
    assign full      = flags.full;

endmodule

// File: rtl/txq_word_queue_chk.sv
module txq_word_queue_chk #(
    parameter int unsigned DEPTH = txq_pkg::TXQ_DEPTH,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_valid,
    input logic             clear,
    input logic             auto_send,
    input logic             pop_ready,
    input logic             pop_valid,
    input logic             sending,
    input logic             empty,
    input logic             half_full,
    input logic             full,
    input logic [LVL_W-1:0] level
);

    assert_pop_has_word_R11: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> !empty);

    assert_pop_gated_R9: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> (auto_send || sending));

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (empty && level == '0));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && !clear && !(pop_valid && pop_ready))
        |=> (full && $stable(level)));

    assert_full_swap_R6: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && pop_valid && pop_ready && !clear)
        |=> (full && level == $past(level)));

    assert_half_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(half_full) |-> $past(push_valid));

    assert_empty_flags_R3: assert property (@(posedge clk) disable iff (rst)
        empty |-> (!half_full && !full));

endmodule

bind txq_word_queue txq_word_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .clear      (clear),
    .auto_send  (auto_send),
    .pop_ready  (pop_ready),
    .pop_valid  (pop_valid),
    .sending    (sending),
    .empty      (empty),
    .half_full  (half_full),
    .full       (full),
    .level      (level)
);

// File: tb/txq_word_queue_tb.sv
`timescale 1ns/1ps
module txq_word_queue_tb;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        clear = 1'b0;
    logic        auto_send = 1'b0;
    logic        send_trigger = 1'b0;
    logic        ser_busy = 1'b0;
    logic        pop_ready = 1'b1;
    logic        pop_valid;
    logic [31:0] pop_data;
    logic [5:0]  level;
    logic        empty, half_full, full, sending;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Scoreboard model
    logic [31:0] mq[$];
    bit          ms = 0;
    bit          mon_on = 0;

    always #2 clk = ~clk;

    txq_word_queue u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .clear(clear), .auto_send(auto_send), .send_trigger(send_trigger),
        .ser_busy(ser_busy), .pop_ready(pop_ready), .pop_valid(pop_valid),
        .pop_data(pop_data), .level(level), .empty(empty), .half_full(half_full),
        .full(full), .sending(sending)
    );

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compares outputs with the model mid-cycle, then advances the model.
    int  sz;
    bit  exp_pv, fire;
    always @(negedge clk) begin
        if (rst) begin
            mq.delete();
            ms = 0;
        end else if (mon_on) begin
            sz = mq.size();
            exp_pv = (auto_send || ms) && sz > 0 && !clear;
            chk("R11 level", level, sz);
            chk("R3 empty", empty, sz == 0);
            chk("R4 half_full", half_full, sz >= 16);
            chk("R5 full", full, sz >= DEPTH);
            chk("R10 sending", sending, ms);
            chk(auto_send ? "R8 pop_valid" : "R9 pop_valid", pop_valid, exp_pv);
            fire = pop_valid && pop_ready;
            if (fire && sz > 0) chk("R2 pop_data order", pop_data, mq[0]);
            if (clear) begin
                mq.delete();
            end else begin
                if (fire && sz > 0) void'(mq.pop_front());
                if (push_valid && (sz < DEPTH || fire)) mq.push_back(push_data);
            end
            if (send_trigger) ms = 1;
            else if (ms && sz == 0 && !ser_busy) ms = 0;
        end
    end

    task automatic push_word(logic [31:0] d);
        push_valid = 1'b1;
        push_data  = d;
        tick();
        push_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(); tick();
        // R1: reset state
        chk("R1 level", level, 0);
        chk("R1 empty", empty, 1);
        chk("R1 half_full", half_full, 0);
        chk("R1 full", full, 0);
        chk("R1 sending", sending, 0);
        chk("R1 pop_valid", pop_valid, 0);
        rst = 1'b0;
        mon_on = 1;
        tick();

        // R9: manual mode holds words until trigger
        for (int i = 0; i < 3; i++) push_word(32'h1000_0000 + i);
        tick(); tick();
        chk("R9 held pop_valid", pop_valid, 0);
        chk("R9 held level", level, 3);
        send_trigger = 1'b1;
        ser_busy = 1'b1;
        tick();
        send_trigger = 1'b0;
        chk("R9 sending after trigger", sending, 1);
        // R10: words added during the drain are also sent
        for (int i = 0; i < 2; i++) push_word(32'h2000_0000 + i);
        repeat (6) tick();
        chk("R10 still sending while busy", sending, 1);
        chk("R10 drained level", level, 0);
        ser_busy = 1'b0;
        tick(); tick();
        chk("R10 sending dropped", sending, 0);
        push_word(32'h3000_0000);
        tick();
        chk("R10 new word held", pop_valid, 0);
        chk("R10 new word level", level, 1);

        // R7: clear wins over a simultaneous push
        clear = 1'b1;
        push_valid = 1'b1;
        push_data = 32'hDEAD_0001;
        tick();
        clear = 1'b0;
        push_valid = 1'b0;
        chk("R7 level after clear", level, 0);
        chk("R7 empty after clear", empty, 1);

        // R4/R5: fill past full with no pops
        pop_ready = 1'b0;
        for (int i = 0; i < 40; i++) begin
            push_word(32'hA000_0000 + i);
            if (i == 14) chk("R4 half at 15", half_full, 0);
            if (i == 15) chk("R4 half at 16", half_full, 1);
        end
        chk("R5 full level", level, 32);
        chk("R5 full flag", full, 1);

        // R6: push and pop together on a full queue
        send_trigger = 1'b1;
        tick();
        send_trigger = 1'b0;
        pop_ready = 1'b1;
        push_word(32'hBBBB_0000);
        chk("R6 level stays", level, 32);
        chk("R6 full stays", full, 1);
        // R2: drain, order checked by the monitor (last word is the swapped-in one)
        repeat (36) tick();
        chk("R2 drained", level, 0);
        chk("R10 idle after drain", sending, 0);

        // R8: automatic mode with irregular pop_ready
        auto_send = 1'b1;
        for (int i = 0; i < 20; i++) begin
            pop_ready = (i % 3) != 0;
            push_word(32'hC000_0000 + i);
        end
        pop_ready = 1'b1;
        repeat (25) tick();
        chk("R8 auto drained", level, 0);
        chk("R8 auto no manual state", sending, 0);

        tick();
        finish_run();
    end

endmodule